// File: doc/BRIEF.md
# Interrupt Source Router

This block is the register front end of a 32-source interrupt controller. Each source has a pending state: its hardware request line ORed with a software-settable bit. A per-source routing register sends each pending source either to the fast interrupt output or to the normal path. The normal path is gated by a per-source enable mask, and the result is handed to the vector stage as a status vector. The fast path ignores the enable mask. Any pending source routed to the fast path raises the single fast output.

Software reaches the block through a synchronous write port and a combinational read port. Both are addressed by word index, where the word index is the byte offset divided by four. The enable and software-request registers have no plain write. Each has one word that sets bits and a separate word that clears bits. Software therefore never needs a read-modify-write to change one source. An identification block at the top of the window returns eight fixed bytes.

Top module: `intc_source_router`

## Requirements
- R1: Reading word 2 (byte 0x08) returns the pending vector, which is `hw_req | soft`.
- R2: `irq_status`, and a read of word 0 (byte 0x00), equal `pending & enable & ~route`. Bit n of `route` set to 1 selects the fast path for source n.
- R3: A read of word 1 (byte 0x04) returns `pending & route`, and enable plays no part in it. `fiq_out` is 1 exactly when that vector is nonzero.
- R4: A write to word 3 (byte 0x0C) replaces `route` with the write data. A read of word 3 returns `route`.
- R5: A write to word 4 (byte 0x10) sets every enable bit that is 1 in the data. A write to word 5 (byte 0x14) clears every enable bit that is 1 in the data. A read of word 4 returns the enable mask.
- R6: A write to word 6 (byte 0x18) sets software-request bits that are 1 in the data. A write to word 7 (byte 0x1C) clears software-request bits that are 1 in the data. A read of word 6 returns the software-request bits.
- R7: A write to word 8 (byte 0x20) stores data bit 0 as a lock flag. A read of word 8 returns that flag in bit 0, with zeros above it. The flag has no effect on any access.
- R8: Reading words 0x3F8 to 0x3FF (bytes 0xFE0 to 0xFFC) returns, in word order, the bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with zeros above.
- R9: Writes to words 0, 1, 2, to unmapped words and to the identification words change no state. Reads of every other word, including 5 and 7, return zero.
- R10: After reset the route, enable, software-request and lock registers are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | NUM_SRC | Hardware request level per source |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_word | input | WORD_W | Word index for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_word` |
| fiq_out | output | 1 | Fast interrupt request |
| irq_status | output | NUM_SRC | Enabled normal-path requests to the vector stage |

## Verification
The bench tests a source that is both routed fast and disabled. A design that let the enable mask gate the fast path would drop `fiq_out` in that case. A design that did not mask routed sources from the normal path would show the same source on `irq_status`. The bench also writes data with mixed bits to the set and clear words, so that a plain overwrite in place of a set or clear leaves the wrong neighbouring bits. It writes to the read-only status words and the identification words, and reads back every register afterwards, which exposes any write decode that aliases those words. It reads words 5 and 7 to catch a read mux that returns the enable or request register there.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned WORD_W = 10;

  localparam logic [WORD_W-1:0] W_IRQ_STAT = 10'h000;
  localparam logic [WORD_W-1:0] W_FIQ_STAT = 10'h001;
  localparam logic [WORD_W-1:0] W_PENDING  = 10'h002;
  localparam logic [WORD_W-1:0] W_ROUTE    = 10'h003;
  localparam logic [WORD_W-1:0] W_EN_SET   = 10'h004;
  localparam logic [WORD_W-1:0] W_EN_CLR   = 10'h005;
  localparam logic [WORD_W-1:0] W_SW_SET   = 10'h006;
  localparam logic [WORD_W-1:0] W_SW_CLR   = 10'h007;
  localparam logic [WORD_W-1:0] W_LOCK     = 10'h008;
  localparam logic [WORD_W-1:0] W_ID_BASE  = 10'h3F8;

  // Identification byte for word (W_ID_BASE + k).
  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h90;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] next_val(input logic [W-1:0] cur,
                                            input logic [W-1:0] d,
                                            input logic s, input logic c);
    logic [W-1:0] r;
    r = cur;
    if (s) r = r | d;
    if (c) r = r & ~d;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= next_val(q, data, set_stb, clr_stb);
  end

  // Shared by the enable (R5) and software-request (R6) registers.
  assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_stb) |=> ((q & $past(data)) == $past(data)));
  assert_clr_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((q & $past(data)) == '0));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(q));
endmodule

// File: rtl/intc_reg_bank.sv
module intc_reg_bank
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [WORD_W-1:0]  word,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] route_q,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] sw_q,
  output logic               lock_q
);
  localparam int unsigned NUM_SC = 2;

  // Named write events.
  logic wr_route_hit, wr_lock_hit, wr_ro_hit;
  logic [NUM_SC-1:0] sc_set, sc_clr;
  logic [NUM_SC-1:0][NUM_SRC-1:0] sc_q;

  assign wr_route_hit = wr && (word == W_ROUTE);
  assign wr_lock_hit  = wr && (word == W_LOCK);
  assign wr_ro_hit    = wr && (word == W_IRQ_STAT || word == W_FIQ_STAT ||
                               word == W_PENDING);
  assign sc_set[0] = wr && (word == W_EN_SET);
  assign sc_clr[0] = wr && (word == W_EN_CLR);
  assign sc_set[1] = wr && (word == W_SW_SET);
  assign sc_clr[1] = wr && (word == W_SW_CLR);

  for (genvar g = 0; g < NUM_SC; g++) begin : g_sc
    intc_setclr_reg #(.W(NUM_SRC)) u_sc (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (sc_set[g]),
      .clr_stb (sc_clr[g]),
      .data    (wdata[NUM_SRC-1:0]),
      .q       (sc_q[g])
    );
  end

  assign en_q = sc_q[0];
  assign sw_q = sc_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (wr_route_hit) route_q <= wdata[NUM_SRC-1:0];
      if (wr_lock_hit)  lock_q  <= wdata[0];
    end
  end

  assert_ro_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ro_hit |=> ($stable(route_q) && $stable(en_q) && $stable(sw_q) && $stable(lock_q)));
  assert_route_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_route_hit |=> (route_q == $past(wdata[NUM_SRC-1:0])));
  assert_lock_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock_hit |=> (lock_q == $past(wdata[0])));
endmodule

// File: rtl/intc_status_calc.sv
module intc_status_calc #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_req,
  input  logic [NUM_SRC-1:0] sw_q,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] route_q,
  output logic [NUM_SRC-1:0] pend_vec,
  output logic [NUM_SRC-1:0] irq_vec,
  output logic [NUM_SRC-1:0] fiq_vec,
  output logic               fiq_any
);
  function automatic logic [NUM_SRC-1:0] f_normal(input logic [NUM_SRC-1:0] p,
                                                  input logic [NUM_SRC-1:0] e,
                                                  input logic [NUM_SRC-1:0] r);
    return p & e & ~r;
  endfunction

  function automatic logic [NUM_SRC-1:0] f_fast(input logic [NUM_SRC-1:0] p,
                                                input logic [NUM_SRC-1:0] r);
    return p & r;
  endfunction

  assign pend_vec = hw_req | sw_q;
  assign irq_vec  = f_normal(pend_vec, en_q, route_q);
  assign fiq_vec  = f_fast(pend_vec, route_q);
  assign fiq_any  = |fiq_vec;

  assert_paths_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec & fiq_vec) == '0);
  assert_irq_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec & ~en_q) == '0);
  assert_fiq_only_routed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_vec & ~route_q) == '0);
  assert_sw_shows_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q & ~pend_vec) == '0);
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  word,
  input  logic [NUM_SRC-1:0] irq_vec,
  input  logic [NUM_SRC-1:0] fiq_vec,
  input  logic [NUM_SRC-1:0] pend_vec,
  input  logic [NUM_SRC-1:0] route_q,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] sw_q,
  input  logic               lock_q,
  output logic [DATA_W-1:0]  rdata
);
  localparam int unsigned ID_HI = WORD_W - 3;

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_SRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NUM_SRC-1:0] = v;
    return r;
  endfunction

  logic id_hit, reg_hit, rd_unmapped;
  assign id_hit  = (word[WORD_W-1:3] == W_ID_BASE[WORD_W-1:3]);
  assign reg_hit = (word == W_IRQ_STAT) || (word == W_FIQ_STAT) ||
                   (word == W_PENDING)  || (word == W_ROUTE)    ||
                   (word == W_EN_SET)   || (word == W_SW_SET)   ||
                   (word == W_LOCK);
  assign rd_unmapped = !id_hit && !reg_hit;

  always_comb begin
    rdata = '0;
    case (word)
      W_IRQ_STAT: rdata = widen(irq_vec);
      W_FIQ_STAT: rdata = widen(fiq_vec);
      W_PENDING:  rdata = widen(pend_vec);
      W_ROUTE:    rdata = widen(route_q);
      W_EN_SET:   rdata = widen(en_q);
      W_SW_SET:   rdata = widen(sw_q);
      W_LOCK:     rdata[0] = lock_q;
      default: if (id_hit) rdata[7:0] = id_byte(word[2:0]);
    endcase
  end

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |-> (rdata == '0));
  assert_id_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit |-> (rdata[DATA_W-1:8] == '0));
  assert_lock_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word == W_LOCK) |-> (rdata[DATA_W-1:1] == '0));
  assert_id_width_ok: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit |-> (word[WORD_W-1:3] == {ID_HI{1'b1}}));
endmodule

// File: rtl/intc_source_router.sv
module intc_source_router
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_req,
  input  logic               reg_wr,
  input  logic [WORD_W-1:0]  reg_word,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               fiq_out,
  output logic [NUM_SRC-1:0] irq_status
);
  logic [NUM_SRC-1:0] route_q, en_q, sw_q;
  logic               lock_q;
  logic [NUM_SRC-1:0] pend_vec, irq_vec, fiq_vec;
  logic               fiq_any;

  intc_reg_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .word    (reg_word),
    .wdata   (reg_wdata),
    .route_q (route_q),
    .en_q    (en_q),
    .sw_q    (sw_q),
    .lock_q  (lock_q)
  );

  intc_status_calc #(.NUM_SRC(NUM_SRC)) u_calc (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_req   (hw_req),
    .sw_q     (sw_q),
    .en_q     (en_q),
    .route_q  (route_q),
    .pend_vec (pend_vec),
    .irq_vec  (irq_vec),
    .fiq_vec  (fiq_vec),
    .fiq_any  (fiq_any)
  );

  intc_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .word     (reg_word),
    .irq_vec  (irq_vec),
    .fiq_vec  (fiq_vec),
    .pend_vec (pend_vec),
    .route_q  (route_q),
    .en_q     (en_q),
    .sw_q     (sw_q),
    .lock_q   (lock_q),
    .rdata    (reg_rdata)
  );

  assign fiq_out    = fiq_any;
  assign irq_status = irq_vec;

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (route_q == '0 && en_q == '0 && sw_q == '0 && !lock_q));
endmodule

// File: tb/intc_source_router_tb_top.sv
module intc_source_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hw_req = '0;
  logic        reg_wr = 1'b0;
  logic [9:0]  reg_word = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fiq_out;
  logic [31:0] irq_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intc_source_router dut_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .reg_wr(reg_wr),
    .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fiq_out(fiq_out), .irq_status(irq_status)
  );

  // Behavioural reference state.
  bit [31:0] m_route, m_en, m_sw;
  bit        m_lock;
  bit [7:0]  id_tab [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_route = 0; m_en = 0; m_sw = 0; m_lock = 0;
    end else if (reg_wr) begin
      if (reg_word == 3) m_route = reg_wdata;
      if (reg_word == 4) m_en = m_en | reg_wdata;
      if (reg_word == 5) m_en = m_en & ~reg_wdata;
      if (reg_word == 6) m_sw = m_sw | reg_wdata;
      if (reg_word == 7) m_sw = m_sw & ~reg_wdata;
      if (reg_word == 8) m_lock = reg_wdata[0];
    end
  end

  function automatic bit [31:0] expect_read(input int w);
    bit [31:0] p;
    p = hw_req | m_sw;
    if (w == 0) return p & m_en & ~m_route;
    if (w == 1) return p & m_route;
    if (w == 2) return p;
    if (w == 3) return m_route;
    if (w == 4) return m_en;
    if (w == 6) return m_sw;
    if (w == 8) return {31'b0, m_lock};
    if (w >= 'h3F8 && w <= 'h3FF) return {24'b0, id_tab[w - 'h3F8]};
    return 0;
  endfunction

  // Every-cycle comparison of the outputs to the vector stage.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [31:0] p, ei;
      bit        ef;
      p  = hw_req | m_sw;
      ei = p & m_en & ~m_route;
      ef = (p & m_route) != 0;
      checks += 2;
      if (irq_status !== ei) begin
        errors++;
        $display("FAIL R2 irq_status actual %h expected %h", irq_status, ei);
      end
      if (fiq_out !== ef) begin
        errors++;
        $display("FAIL R3 fiq_out actual %b expected %b", fiq_out, ef);
      end
    end
  end

  task automatic do_wr(input int w, input bit [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_word = w[9:0]; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input int w, input bit [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_word = w[9:0];
    @(negedge clk);
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s word %0h actual %h expected %h", tag, w, reg_rdata, exp);
    end
  endtask

  task automatic rd_model(input int w, input string tag);
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_word = w[9:0];
    @(negedge clk);
    checks++;
    if (reg_rdata !== expect_read(w)) begin
      errors++;
      $display("FAIL %s word %0h actual %h expected %h", tag, w, reg_rdata, expect_read(w));
    end
  endtask

  task automatic fiq_exp(input bit exp, input string tag);
    @(negedge clk);
    checks++;
    if (fiq_out !== exp) begin
      errors++;
      $display("FAIL %s fiq_out actual %b expected %b", tag, fiq_out, exp);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state.
    rd_exp(3, 0, "R10"); rd_exp(4, 0, "R10");
    rd_exp(6, 0, "R10"); rd_exp(8, 0, "R10");

    // R8: identification bytes.
    for (int k = 0; k < 8; k++) rd_exp('h3F8 + k, {24'b0, id_tab[k]}, "R8");

    // R5: set then clear with mixed data.
    do_wr(4, 32'h0000_F0F1);
    rd_exp(4, 32'h0000_F0F1, "R5");
    do_wr(5, 32'h0000_0031);
    rd_exp(4, 32'h0000_F0C0, "R5");
    @(posedge clk); #1 hw_req = 32'h0000_00FF;
    rd_exp(0, 32'h0000_00C0, "R2");

    // R4 and R3: route some sources fast.
    do_wr(3, 32'h0000_0F0F);
    rd_exp(3, 32'h0000_0F0F, "R4");
    rd_exp(1, 32'h0000_000F, "R3");
    rd_exp(0, 32'h0000_00C0, "R2");
    do_wr(5, 32'hFFFF_FFFF);
    fiq_exp(1'b1, "R3");
    rd_exp(1, 32'h0000_000F, "R3");
    rd_exp(0, 32'h0, "R2");

    // R6 and R1: software requests.
    do_wr(6, 32'h8000_0101);
    rd_exp(6, 32'h8000_0101, "R6");
    rd_exp(2, 32'h8000_01FF, "R1");
    do_wr(7, 32'h0000_0100);
    rd_exp(6, 32'h8000_0001, "R6");
    @(posedge clk); #1 hw_req = 32'h0;
    rd_exp(2, 32'h8000_0001, "R1");
    do_wr(7, 32'hFFFF_FFFF);
    fiq_exp(1'b0, "R3");

    // R7: lock flag stored, no effect.
    do_wr(8, 32'hFFFF_FFFF);
    rd_exp(8, 32'h1, "R7");
    do_wr(4, 32'h0000_0003);
    rd_exp(4, 32'h0000_0003, "R7");
    do_wr(8, 32'h0000_0002);
    rd_exp(8, 32'h0, "R7");

    // R9: ignored writes and zero reads.
    do_wr(0, 32'hFFFF_FFFF); do_wr(1, 32'hFFFF_FFFF); do_wr(2, 32'hFFFF_FFFF);
    do_wr(9, 32'hFFFF_FFFF); do_wr('h3F8, 32'hFFFF_FFFF); do_wr('h100, 32'hFFFF_FFFF);
    rd_exp(3, 32'h0000_0F0F, "R9"); rd_exp(4, 32'h0000_0003, "R9");
    rd_exp(6, 32'h0, "R9");         rd_exp(8, 32'h0, "R9");
    rd_exp(5, 0, "R9"); rd_exp(7, 0, "R9"); rd_exp(9, 0, "R9");
    rd_exp('h100, 0, "R9"); rd_exp('h3F7, 0, "R9");

    // Mixed traffic against the reference model.
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1 hw_req = $urandom;
      do_wr($urandom_range(0, 9), $urandom);
      rd_model($urandom_range(0, 9), "R1 R2 R3 R4 R5 R6");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule